// File: doc/BRIEF.md
# Bus-Start Watchdog Reset Supervisor

This block produces the system reset. It keeps an active-low reset output asserted after power-up and whenever the supply is reported bad. Once the supply has been good for a fixed hold time of 250 ms, it releases the reset. While the system runs, a watchdog counts down a selectable period. The only thing that restarts the count is a START condition on a two-wire serial bus: the data line falls while the clock line is high. If the count runs out before a START arrives, the block asserts reset for one 250 ms hold time and then starts watching again.

The bus lines pass through a synchronizer before the START detector sees them. A 2-bit select input picks the watchdog period or switches the watchdog off. The supply-good flag comes from an external comparator that is already timed to the system clock. Every millisecond period is a whole number of `CYC_PER_MS` clock cycles, so a small value of that parameter turns the periods into a few hundred cycles.

Top module: `bus_wdt_supervisor`

## Requirements
- R1: While rst_ni is low, rst_no is low, from the moment rst_ni falls and without waiting for a clock edge.
- R2: When rst_ni rises with supply_ok_i high, rst_no stays low for exactly RST_CYC = 250*CYC_PER_MS clock cycles and then rises.
- R3: Select codes on wd_sel_i: 2'b10 gives 250 ms, 2'b01 gives 750 ms, 2'b00 gives 1750 ms, and 2'b11 switches the watchdog off. With no START, rst_no stays high for exactly P = ms*CYC_PER_MS cycles after it rises and then falls.
- R4: A START is a falling SDA while SCL is high, seen after the two-stage synchronizer. It reloads the full period. If SDA falls in high cycle k (cycle 0 is the first cycle after rst_no rises), rst_no stays high for k+3+P cycles.
- R5: When the watchdog expires, rst_no stays low for exactly RST_CYC cycles and then rises.
- R6: A START that arrives while rst_no is low does not change the length of the pulse or the period that follows it.
- R7: With wd_sel_i = 2'b11, the count stops and rst_no stays high for as long as the code is held.
- R8: While rst_no is high, a change of wd_sel_i reloads the newly selected period. A change in high cycle n gives a high time of n+1+P_new.
- R9: A low supply_ok_i drives rst_no low at the next clock edge and keeps it low. If supply_ok_i returns high in low cycle j, rst_no is released after j+RST_CYC low cycles. A new drop during the pulse restarts the hold time.
- R10: If supply_ok_i is low when rst_ni rises, rst_no stays low until the supply has been good for RST_CYC cycles.
- R11: If SDA falls while SCL is low and SCL rises later, that is not a START. The period is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| sda_i | input | 1 | Serial data line, asynchronous |
| scl_i | input | 1 | Serial clock line, asynchronous |
| supply_ok_i | input | 1 | Supply-good flag, synchronous to clk_i |
| wd_sel_i | input | 2 | Watchdog period select |
| rst_no | output | 1 | System reset output, active low |

## Verification
The properties assume that supply_ok_i and wd_sel_i are already synchronous to clk_i, because neither one passes through a synchronizer. They also assume that a select change is a single clean step and not a glitch. The bench drives every input on the falling clock edge. It holds each SDA and SCL level for at least two cycles, so the synchronizer captures every transition and the START detector sees every edge of the bus. Expected high and low durations are computed from the select code and from the cycle in which each stimulus was applied.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  typedef enum logic [1:0] {
    SEL_1750 = 2'b00,
    SEL_750  = 2'b01,
    SEL_250  = 2'b10,
    SEL_OFF  = 2'b11
  } wd_sel_e;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } sup_state_e;

  localparam int unsigned RST_MS = 250;
  localparam int unsigned MAX_MS = 1750;

  function automatic int unsigned period_ms(input logic [1:0] sel);
    case (sel)
      SEL_250:  return 250;
      SEL_750:  return 750;
      SEL_1750: return 1750;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/wdr_sync.sv
module wdr_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_BIT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= {WIDTH{RST_BIT}};
        else         stage_q[g] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= {WIDTH{RST_BIT}};
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wdr_start_det.sv
module wdr_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o
);

  logic sda_q, scl_q;

  // idle bus level on reset so no false START is seen afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;

endmodule

// File: rtl/wdr_wd_timer.sv
module wdr_wd_timer
  import wdr_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);

  localparam int unsigned MAX_CYC = MAX_MS * CYC_PER_MS;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    sel_q;
  logic          reload, off;

  function automatic logic [CW-1:0] load_val(input logic [1:0] s);
    int unsigned p;
    p = period_ms(s) * CYC_PER_MS;
    if (p == 0) return '0;
    return CW'(p - 1);
  endfunction

  assign off    = (sel_i == SEL_OFF);
  // held loaded while reset is out, so a START in the pulse leaves nothing behind
  assign reload = !run_i || start_i || (sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_OFF;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (reload)                   cnt_q <= load_val(sel_i);
      else if (!off && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_i && !reload && !off && (cnt_q == '0);

endmodule

// File: rtl/wdr_rst_ctrl.sv
module wdr_rst_ctrl
  import wdr_pkg::*;
#(
  parameter int unsigned RST_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic expire_i,
  output logic run_o
);

  localparam int unsigned RW = $clog2(RST_CYC + 1);

  sup_state_e    state_q;
  logic [RW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      hold_q  <= '0;
    end else begin
      case (state_q)
        ST_HOLD: begin
          if (!supply_ok_i) begin
            hold_q <= '0;
          end else if (hold_q == RW'(RST_CYC - 1)) begin
            state_q <= ST_RUN;
            hold_q  <= '0;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        default: begin
          if (!supply_ok_i || expire_i) begin
            state_q <= ST_HOLD;
            hold_q  <= '0;
          end
        end
      endcase
    end
  end

  assign run_o = (state_q == ST_RUN);

endmodule

// File: rtl/bus_wdt_supervisor.sv
module bus_wdt_supervisor
  import wdr_pkg::*;
#(
  parameter int unsigned CYC_PER_MS  = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic       supply_ok_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_no
);

  localparam int unsigned RST_CYC = RST_MS * CYC_PER_MS;

  logic [1:0] bus_sync;
  logic       bus_start;
  logic       wd_expire;
  logic       sys_run;

  wdr_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_BIT(1'b1)
  ) i_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_i, scl_i}),
    .q_o   (bus_sync)
  );

  wdr_start_det i_start_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sda_i  (bus_sync[1]),
    .scl_i  (bus_sync[0]),
    .start_o(bus_start)
  );

  wdr_wd_timer #(
    .CYC_PER_MS(CYC_PER_MS)
  ) i_wd_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (sys_run),
    .start_i (bus_start),
    .sel_i   (wd_sel_i),
    .expire_o(wd_expire)
  );

  wdr_rst_ctrl #(
    .RST_CYC(RST_CYC)
  ) i_rst_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .expire_i   (wd_expire),
    .run_o      (sys_run)
  );

  assign rst_no = sys_run;

endmodule

// File: rtl/bus_wdt_checker.sv
module bus_wdt_checker #(
  parameter int unsigned RST_CYC = 250000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic [1:0] wd_sel_i,
  input logic       rst_no,
  input logic       wd_expire_i
);

  int unsigned low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_cnt <= 0;
    else if (rst_no)                   low_cnt <= 0;
    else if (low_cnt != 32'hFFFF_FFFF) low_cnt <= low_cnt + 1;
  end

  AST_SUPPLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !rst_no); // R9

  AST_RELEASE_ON_GOOD_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(supply_ok_i)); // R10

  AST_PULSE_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> low_cnt >= RST_CYC); // R5

  AST_EXPIRY_TRIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire_i |=> !rst_no); // R3

  AST_OFF_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_no) && $past(supply_ok_i) && $past(wd_sel_i) == 2'b11) |-> rst_no); // R7

endmodule

bind bus_wdt_supervisor bus_wdt_checker #(
  .RST_CYC(RST_CYC)
) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .wd_sel_i   (wd_sel_i),
  .rst_no     (rst_no),
  .wd_expire_i(wd_expire)
);

// File: tb/test_bus_wdt_supervisor.sv
module test_bus_wdt_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 1;
  localparam int RST        = 250 * CPM;
  localparam int LAT        = 3;
  localparam int NONE       = -1000;

  logic       clk = 1'b0;
  logic       rst_n, sda, scl, supply_ok, rst_no;
  logic [1:0] wd_sel;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;
  int         n;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wdt_supervisor #(.CYC_PER_MS(CPM), .SYNC_STAGES(2)) i_bus_wdt_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_i(scl),
    .supply_ok_i(supply_ok), .wd_sel_i(wd_sel), .rst_no(rst_no)
  );

  function automatic int per(input logic [1:0] s);
    case (s)
      2'b10:   return 250 * CPM;
      2'b01:   return 750 * CPM;
      2'b00:   return 1750 * CPM;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called on a falling edge with rst_no high; counts high cycles
  task automatic run_high(input int kick, input bit scl_mode, input int sel_at,
                          input logic [1:0] new_sel, input int drop_at,
                          input int limit, output int cnt);
    cnt = 0;
    while (rst_no === 1'b1 && cnt < limit) begin
      if (cnt == kick) begin if (scl_mode) scl = 1'b0; else sda = 1'b0; end
      if (cnt == kick + 2) begin if (scl_mode) sda = 1'b0; else sda = 1'b1; end
      if (cnt == kick + 4 && scl_mode) scl = 1'b1;
      if (cnt == kick + 6 && scl_mode) sda = 1'b1;
      if (cnt == sel_at) wd_sel = new_sel;
      if (cnt == drop_at) supply_ok = 1'b0;
      cnt++;
      @(negedge clk);
    end
    sda = 1'b1;
    scl = 1'b1;
  endtask

  // called on a falling edge with rst_no low; counts low cycles
  task automatic run_low(input int kick, input int drop_at, input int rise_at,
                         output int cnt);
    cnt = 0;
    while (rst_no === 1'b0 && cnt < 5000) begin
      if (cnt == kick) sda = 1'b0;
      if (cnt == kick + 2) sda = 1'b1;
      if (cnt == drop_at) supply_ok = 1'b0;
      if (cnt == rise_at) supply_ok = 1'b1;
      cnt++;
      @(negedge clk);
    end
    sda = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [1:0] sels [3];
    sels[0] = 2'b10; sels[1] = 2'b01; sels[2] = 2'b00;
    rst_n = 1'b0; sda = 1'b1; scl = 1'b1; supply_ok = 1'b0; wd_sel = 2'b10;
    repeat (5) @(negedge clk);
    chk("R1 reset holds output low", int'(rst_no), 0);
    rst_n = 1'b1;
    run_low(NONE, NONE, 40, n);
    chk("R10 power-up with bad supply", n, 40 + RST);
    run_high(NONE, 0, NONE, 2'b10, NONE, 5000, n);
    chk("R3 period 2'b10 unkicked", n, per(2'b10));

    for (int s = 0; s < 3; s++) begin
      int ks [5];
      ks[0] = NONE; ks[1] = 0; ks[2] = 7;
      ks[3] = per(sels[s]) / 2; ks[4] = per(sels[s]) - 4;
      for (int k = 0; k < 5; k++) begin
        wd_sel = sels[s];
        run_low(NONE, NONE, NONE, n);
        chk("R5 expiry pulse width", n, RST);
        run_high(ks[k], 0, NONE, 2'b00, NONE, 5000, n);
        if (ks[k] == NONE) chk("R3 unkicked period", n, per(sels[s]));
        else               chk("R4 START reload", n, ks[k] + LAT + per(sels[s]));
      end
    end

    wd_sel = 2'b10;
    for (int i = 0; i < 2; i++) begin
      run_low(i == 0 ? 100 : RST - 10, NONE, NONE, n);
      chk("R6 START in pulse: width", n, RST);
      run_high(NONE, 0, NONE, 2'b00, NONE, 5000, n);
      chk("R6 START in pulse: next period", n, per(2'b10));
    end

    run_low(NONE, NONE, NONE, n);
    chk("R5 expiry pulse width", n, RST);
    run_high(20, 1, NONE, 2'b00, NONE, 5000, n);
    chk("R11 SDA fall with SCL low ignored", n, per(2'b10));

    wd_sel = 2'b11;
    run_low(NONE, NONE, NONE, n);
    chk("R5 expiry pulse width", n, RST);
    run_high(NONE, 0, NONE, 2'b00, NONE, 3000, n);
    chk("R7 disabled never trips", n, 3000);
    run_high(NONE, 0, 0, 2'b10, NONE, 5000, n);
    chk("R8 off to 250ms reload", n, 0 + 1 + per(2'b10));
    run_low(NONE, NONE, NONE, n);
    chk("R5 expiry pulse width", n, RST);
    run_high(NONE, 0, 100, 2'b00, NONE, 5000, n);
    chk("R8 select change reload", n, 100 + 1 + per(2'b00));

    run_low(NONE, NONE, NONE, n);
    chk("R5 expiry pulse width", n, RST);
    run_high(NONE, 0, NONE, 2'b00, 60, 5000, n);
    chk("R9 supply drop trips next cycle", n, 61);
    wd_sel = 2'b10;
    run_low(NONE, NONE, 30, n);
    chk("R9 release after supply recovers", n, 30 + RST);
    run_high(NONE, 0, NONE, 2'b00, NONE, 5000, n);
    chk("R3 period after supply event", n, per(2'b10));
    run_low(NONE, 100, 130, n);
    chk("R9 drop in pulse restarts hold", n, 130 + RST);

    rst_n = 1'b0;
    #1;
    chk("R1 asynchronous reset assertion", int'(rst_no), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_low(NONE, NONE, NONE, n);
    chk("R2 power-up hold time", n, RST);
    run_high(NONE, 0, NONE, 2'b00, NONE, 5000, n);
    chk("R3 period after power-up", n, per(2'b10));

    finish_run();
  end

endmodule